// File: doc/BRIEF.md
# Isolated Digital I/O Register Block

This block is the register front end of a digital I/O peripheral. It has sixteen driven output lines and sixteen sensed input lines, and it is reached over a byte-wide synchronous bus. Software writes the two output bytes and reads them back, so it can change one bit with a read-modify-write. It reads the two input bytes, and it reads a status byte that says which half of the inputs has changed since the last acknowledge.

Several registers act on the kind of bus access and ignore the data. A read of the interrupt control address arms the interrupt line and a write disarms it. A read of the filter control address turns input debouncing on for all sixteen lines and a write turns it off. A write of any value to the low input address acknowledges pending changes. Inputs pass through a two-flop synchronizer. When filtering is on, a new level is accepted only after it has been held for a set number of clocks. The interrupt line reports both rising and falling edges.

Top module: `iso_dio_regs`

## Requirements
- R1: After reset the output pins are 0, `irq` is 0, `bus_rdata` is 0, the status byte (offset 6) reads 0, interrupts are disarmed and filtering is off.
- R2: Offset 0 holds output lines 7..0 and offset 4 holds lines 15..8. A write sets `out_pins` from the next clock, and a read of either offset returns the byte last written.
- R3: Offset 1 reads the conditioned inputs 7..0 and offset 5 reads inputs 15..8. Writes to offsets 5, 6 and 7 change neither the outputs nor the status byte. Offsets 2, 3 and 7 read as 0.
- R4: A write of any data to offset 1 clears all pending status bits, and `irq` is low in the following cycle.
- R5: A read of offset 2 arms the interrupt and a write to offset 2 disarms it. When both happen in the same cycle the write wins. Disarming does not clear pending status.
- R6: A read of offset 3 turns filtering on and a write to offset 3 turns it off.
- R7: With filtering off, an input change is readable 3 clocks after it is sampled: a read strobe at the 4th rising edge after the pin change returns the new value, and a strobe at the 3rd edge returns the old one. With filtering on, the new level must be held on the synchronized input for STABLE_CYCLES (default 4) consecutive clocks. A read strobe at the 7th edge after the change returns the new value and one at the 6th returns the old value. A 2-clock pulse is discarded and sets no status.
- R8: Status byte at offset 6: bit 0 is set by any accepted edge (rising or falling) on inputs 7..0, bit 1 by one on inputs 15..8, bit 2 is set while bit 0 or bit 1 is set, and bits 7..3 are 0. `irq` equals bit 2 AND the armed flag. It is therefore high only when bit 2 and at least one of bits 0..1 are set.
- R9: Each clock cycle with `bus_rd` high is one read access. `bus_rdata` updates at the clock edge that samples the strobe and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_pins | output | 16 | Output line drive |
| in_pins | input | 16 | Raw input lines |
| irq | output | 1 | Interrupt request, high while pending and armed |

## Verification
A wrong armed flag or a stale pending bit shows on `irq` in the cycle after the bus access that should have changed it. A debounce counter that fails to restart shows as a discarded pulse setting a status bit, or as an accepted level that appears one clock early or late in the input byte read back. The bench issues a read strobe on every clock after a pin change, so a wrong count of synchronizer or filter stages gives a value off by one read. A wrong half-select in the edge logic shows as the wrong status bit.

// File: rtl/dio_pkg.sv
package dio_pkg;

  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_OUT_LO  = 3'd0,
    A_IN_LO   = 3'd1,
    A_IRQ_CTL = 3'd2,
    A_FILT    = 3'd3,
    A_OUT_HI  = 3'd4,
    A_IN_HI   = 3'd5,
    A_STAT    = 3'd6,
    A_SPARE   = 3'd7
  } reg_addr_e;

  // status byte layout: [0] low half changed, [1] high half changed, [2] any pending
  function automatic logic [DW-1:0] pack_status(input logic lo_seen, input logic hi_seen);
    return {5'b0, lo_seen | hi_seen, hi_seen, lo_seen};
  endfunction

  // the device is the interrupt source only with a half bit and the summary bit set
  function automatic logic status_is_ours(input logic [DW-1:0] s);
    return (|s[1:0]) & s[2];
  endfunction

  // a line takes a new level when it differs and either filtering is off or the hold is done
  function automatic logic accept_level(input logic differs, input logic filt, input logic hold_done);
    return differs & (~filt | hold_done);
  endfunction

endpackage

// File: rtl/dio_in_cond.sv
module dio_in_cond #(
  parameter int LINES  = 16,
  parameter int STABLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_en,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean,
  output logic [LINES-1:0] chg
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [LINES-1:0] sync1, sync2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [CW-1:0] hold_cnt;
    logic          lvl_q;
    logic          differs;
    logic          take;

    assign differs = sync2[g] ^ lvl_q;
    assign take    = dio_pkg::accept_level(differs, filt_en, hold_cnt == LAST);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_cnt <= '0;
        lvl_q    <= 1'b0;
      end else if (!differs) begin
        hold_cnt <= '0;
      end else if (take) begin
        lvl_q    <= sync2[g];
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end

    assign clean[g] = lvl_q;
    assign chg[g]   = take;
  end

endmodule

// File: rtl/dio_irq_unit.sv
module dio_irq_unit #(
  parameter int LINES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       chg,
  input  logic                   ack,
  input  logic                   arm,
  input  logic                   disarm,
  output logic                   irq_en,
  output logic [dio_pkg::DW-1:0] stat,
  output logic                   irq
);
  localparam int HALF = LINES / 2;

  logic lo_hit, hi_hit;
  logic seen_lo, seen_hi;

  assign lo_hit = |chg[HALF-1:0];
  assign hi_hit = |chg[LINES-1:HALF];

  // a new edge in the acknowledge cycle is kept so that no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_lo <= 1'b0;
      seen_hi <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (lo_hit)   seen_lo <= 1'b1;
      else if (ack) seen_lo <= 1'b0;
      if (hi_hit)   seen_hi <= 1'b1;
      else if (ack) seen_hi <= 1'b0;
      if (disarm)   irq_en  <= 1'b0;
      else if (arm) irq_en  <= 1'b1;
    end
  end

  assign stat = dio_pkg::pack_status(seen_lo, seen_hi);
  assign irq  = stat[2] & irq_en;

endmodule

// File: rtl/iso_dio_regs.sv
module iso_dio_regs #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [15:0] out_pins,
  input  logic [15:0] in_pins,
  output logic        irq
);
  import dio_pkg::*;

  localparam int LINES = 2 * DW;
  localparam int NREG  = 1 << AW;

  logic [NREG-1:0]  sel, wr_sel, rd_sel;
  logic [DW-1:0]    out_lo, out_hi;
  logic [LINES-1:0] clean, chg;
  logic [DW-1:0]    stat_byte;
  logic [DW-1:0]    rd_mux;
  logic             filt_en;
  logic             irq_en;
  logic             any_chg;

  assign sel    = NREG'(1) << bus_addr;
  assign wr_sel = sel & {NREG{bus_wr}};
  assign rd_sel = sel & {NREG{bus_rd}};

  // output bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_lo <= '0;
      out_hi <= '0;
    end else begin
      if (wr_sel[A_OUT_LO]) out_lo <= bus_wdata;
      if (wr_sel[A_OUT_HI]) out_hi <= bus_wdata;
    end
  end
  assign out_pins = {out_hi, out_lo};

  // filter flag: access type decides, write wins
  always_ff @(posedge clk) begin
    if (!rst_n)                filt_en <= 1'b0;
    else if (wr_sel[A_FILT])   filt_en <= 1'b0;
    else if (rd_sel[A_FILT])   filt_en <= 1'b1;
  end

  dio_in_cond #(.LINES(LINES), .STABLE(STABLE_CYCLES)) in_cond_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt_en (filt_en),
    .raw     (in_pins),
    .clean   (clean),
    .chg     (chg)
  );

  assign any_chg = |chg;

  dio_irq_unit #(.LINES(LINES)) irq_unit_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .chg    (chg),
    .ack    (wr_sel[A_IN_LO]),
    .arm    (rd_sel[A_IRQ_CTL]),
    .disarm (wr_sel[A_IRQ_CTL]),
    .irq_en (irq_en),
    .stat   (stat_byte),
    .irq    (irq)
  );

  always_comb begin
    case (reg_addr_e'(bus_addr))
      A_OUT_LO: rd_mux = out_lo;
      A_IN_LO:  rd_mux = clean[DW-1:0];
      A_OUT_HI: rd_mux = out_hi;
      A_IN_HI:  rd_mux = clean[LINES-1:DW];
      A_STAT:   rd_mux = stat_byte;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/iso_dio_regs_chk.sv
module iso_dio_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [15:0] out_pins,
  input logic        irq,
  input logic        irq_en,
  input logic        filt_en,
  input logic        any_chg,
  input logic [7:0]  stat_byte
);
  import dio_pkg::*;

  logic ro_wr;
  assign ro_wr = bus_wr && (bus_addr != A_OUT_LO) && (bus_addr != A_OUT_HI);

  AST_OUT_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_OUT_LO |=> out_pins[7:0] == $past(bus_wdata)); // R2
  AST_OUT_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_OUT_HI |=> out_pins[15:8] == $past(bus_wdata)); // R2
  AST_OTHER_WRITE_KEEPS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> $stable(out_pins)); // R3
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_IN_LO && !any_chg |=> !irq); // R4
  AST_CTL_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_IRQ_CTL |=> !irq_en && !irq); // R5
  AST_CTL_READ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == A_IRQ_CTL |=> irq_en); // R5
  AST_FILT_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_FILT |=> !filt_en); // R6
  AST_FILT_READ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == A_FILT |=> filt_en); // R6
  AST_IRQ_IS_OURS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_is_ours(stat_byte) && stat_byte[7:3] == 5'b0); // R8
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en); // R8

endmodule

bind iso_dio_regs iso_dio_regs_chk chk_i (.*);

// File: tb/iso_dio_regs_tb_top.sv
module iso_dio_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] out_pins;
  logic [15:0] in_pins;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  iso_dio_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_pins  (out_pins),
    .in_pins   (in_pins),
    .irq       (irq)
  );

  // expected status byte restated from R8
  function automatic logic [7:0] exp_stat(input logic lo, input logic hi);
    logic [7:0] s;
    s = 8'h00;
    if (lo) s = s | 8'h01;
    if (hi) s = s | 8'h02;
    if (lo || hi) s = s | 8'h04;
    return s;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1", "pins in reset", out_pins, 16'h0);
    check("R1", "irq in reset", {15'b0, irq}, 16'h0);
    check("R1", "rdata in reset", {8'h0, bus_rdata}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd6, d); check("R1", "status after reset", {8'h0, d}, 16'h0);
    rd(3'd0, d); check("R1", "out lo after reset", {8'h0, d}, 16'h0);
  endtask

  task automatic t_outputs;
    logic [7:0] d;
    wr(3'd0, 8'h5A);
    wr(3'd4, 8'hC3);
    check("R2", "pins after writes", out_pins, 16'hC35A);
    rd(3'd0, d); check("R2", "readback lo", {8'h0, d}, 16'h005A);
    rd(3'd4, d); check("R2", "readback hi", {8'h0, d}, 16'h00C3);
    wr(3'd0, d | 8'h01);
    rd(3'd0, d); check("R2", "rmw lo", {8'h0, d}, 16'h00C3);
    check("R2", "pins after rmw", out_pins, 16'hC3C3);
  endtask

  task automatic t_sync_unfiltered;
    logic [7:0] v [4];
    in_pins[7:0] = 8'hA5;
    for (int i = 0; i < 4; i++) rd(3'd1, v[i]);
    check("R7", "unfiltered third strobe old", {8'h0, v[2]}, 16'h0000);
    check("R7", "unfiltered fourth strobe new", {8'h0, v[3]}, 16'h00A5);
    rd(3'd6, v[0]); check("R8", "status low half", {8'h0, v[0]}, {8'h0, exp_stat(1'b1, 1'b0)});
    check("R8", "no irq while disarmed", {15'b0, irq}, 16'h0);
    wr(3'd1, 8'h00);
    rd(3'd6, v[0]); check("R4", "ack clears status", {8'h0, v[0]}, 16'h0);
  endtask

  task automatic t_filter;
    logic [7:0] v [7];
    logic [7:0] d;
    rd(3'd3, d);
    in_pins[15:8] = 8'h3C;
    for (int i = 0; i < 7; i++) rd(3'd5, v[i]);
    check("R7", "filtered sixth strobe old", {8'h0, v[5]}, 16'h0000);
    check("R7", "filtered seventh strobe new", {8'h0, v[6]}, 16'h003C);
    wr(3'd1, 8'hFF);
    in_pins[1] = 1'b1; idle(2); in_pins[1] = 1'b0; idle(8);
    rd(3'd6, d); check("R7", "short pulse dropped", {8'h0, d}, 16'h0);
    rd(3'd1, d); check("R7", "low byte unchanged", {8'h0, d}, 16'h00A5);
    wr(3'd3, 8'h00);
    in_pins[1] = 1'b1; idle(2); in_pins[1] = 1'b0; idle(8);
    rd(3'd6, d); check("R6", "pulse seen with filter off", {8'h0, d}, {8'h0, exp_stat(1'b1, 1'b0)});
    wr(3'd1, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    rd(3'd2, d);
    check("R5", "armed without event", {15'b0, irq}, 16'h0);
    in_pins[15:8] = 8'h38; idle(5);
    check("R8", "falling edge irq", {15'b0, irq}, 16'h1);
    rd(3'd6, d); check("R8", "status high half", {8'h0, d}, {8'h0, exp_stat(1'b0, 1'b1)});
    wr(3'd1, 8'h77);
    check("R4", "ack drops irq", {15'b0, irq}, 16'h0);
    in_pins[7:0] = 8'hA7; idle(5);
    check("R8", "rising edge irq", {15'b0, irq}, 16'h1);
    wr(3'd2, 8'hFF);
    check("R5", "write disarms", {15'b0, irq}, 16'h0);
    rd(3'd6, d); check("R5", "disarm keeps status", {8'h0, d}, {8'h0, exp_stat(1'b1, 1'b0)});
    bus_addr = 3'd2; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
    check("R5", "write wins over read", {15'b0, irq}, 16'h0);
    rd(3'd2, d);
    check("R5", "read rearms", {15'b0, irq}, 16'h1);
    check("R3", "ctl reads zero", {8'h0, d}, 16'h0);
  endtask

  task automatic t_inert;
    logic [7:0] d;
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    check("R3", "pins after inert writes", out_pins, 16'hC3C3);
    rd(3'd6, d); check("R3", "status after inert writes", {8'h0, d}, {8'h0, exp_stat(1'b1, 1'b0)});
    rd(3'd5, d); check("R3", "high inputs", {8'h0, d}, 16'h0038);
    rd(3'd7, d); check("R3", "spare reads zero", {8'h0, d}, 16'h0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    rd(3'd4, d);
    idle(3);
    check("R9", "rdata held when idle", {8'h0, bus_rdata}, 16'h00C3);
    bus_addr = 3'd0; idle(2);
    check("R9", "address change alone", {8'h0, bus_rdata}, 16'h00C3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; in_pins = '0;
    repeat (3) @(negedge clk);
    t_reset;
    t_outputs;
    t_sync_unfiltered;
    t_filter;
    t_irq;
    t_inert;
    t_hold;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule